// File: doc/BRIEF.md
# Half-Duplex Transmit Deferral and Backoff Controller

This block decides when an Ethernet MAC transmitter may put a frame on the wire and when it must give up. It watches carrier sense and lets a start request through only once the line has been quiet for a full interframe gap. The gap is counted in bit times that a bit-time enable marks. If a collision is seen while a half-duplex frame is going out, the block stops the data, raises a jam indication for a fixed number of bit times, and then waits a random whole number of slot times. After that wait it defers again and retries.

The random wait follows truncated exponential backoff. After collision n the wait is r slots, with r drawn from a free-running LFSR and masked to k bits. In the standard setting k = min(n, EXP_MAX). A strap sampled while reset is asserted can cap the exponent at EXP_SHORT instead. When ATTEMPT_MAX collisions have hit the same frame, the frame is dropped and a one-clock abort flag is raised. In full-duplex operation the collision input and carrier sense play no part. Serialising the frame and computing its CRC belong to the transmitter around this block.

Top module: `txdefer_top`

## Requirements
- R1: While reset is held and on the first clock after it is released, txGo, txJam and txAbort are all low. The gap counter starts empty, so an IFG of idle bit ticks must follow reset before any start.
- R2: If the line has already been idle for at least IFG_BITS bit ticks, raising txReq makes txGo rise on the second clock edge after txReq is first sampled high. txGo stays high until txEnd or a collision. txGo rises only while txReq was high on the previous clock.
- R3: In half duplex, a high crs clears the idle count, and txGo stays low while a request waits on a busy line. txGo rises on the edge after the IFG_BITS-th bit tick of uninterrupted idle carrier. With bitEn held high, that is IFG_BITS+1 clocks after the first idle clock.
- R4: In half duplex, col sampled high while txGo is high makes txJam rise and txGo fall on the next clock. txJam never rises for any other cause.
- R5: txJam stays high for exactly JAM_BITS clocks on which bitEn is high, whatever the pattern of bitEn.
- R6: After collision n the controller waits r·SLOT_BITS bit ticks, with 0 ≤ r ≤ 2^k−1 and k = min(n, EXP_MAX), and then defers for a fresh gap. With bitEn held high and the line idle, txGo returns exactly r·SLOT_BITS + IFG_BITS + 2 clocks after the first clock on which txJam is low.
- R7: Carrier seen during or after the backoff wait restarts the gap. The retry starts IFG_BITS+1 clocks after the carrier drops, even when the backoff expired while the carrier was high.
- R8: With fullDuplex high, col is ignored: txGo stays high and txJam stays low. crs is also ignored for deferral, so a start on a busy line still takes two clocks.
- R9: When the collision that ends a jam is the ATTEMPT_MAX-th of the frame, txAbort is high for exactly one clock, on the first clock after txJam falls. No retry follows. Collisions before that point never raise txAbort.
- R10: backoffCapStrap is sampled on every clock edge while rstN is low. If it was high, k = min(n, EXP_SHORT), so every draw is below 2^EXP_SHORT. Changes to the strap after reset have no effect. With the strap low, draws above 2^EXP_SHORT − 1 do occur.
- R11: The collision count restarts for every new frame, so the first collision of a frame that follows an aborted one draws r from {0, 1}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset: asynchronous for the control state, and used to sample the strap |
| bitEn | input | 1 | One-clock pulse per bit time |
| crs | input | 1 | Carrier sense from the line |
| col | input | 1 | Collision detect from the line |
| fullDuplex | input | 1 | High selects full-duplex operation |
| backoffCapStrap | input | 1 | Strap that caps the backoff exponent; sampled during reset |
| txReq | input | 1 | Frame waiting to be sent; held until txEnd or txAbort |
| txEnd | input | 1 | One-clock pulse when the frame has been fully sent |
| txGo | output | 1 | Transmitter may send frame data |
| txJam | output | 1 | Transmitter must send the jam pattern |
| txAbort | output | 1 | One-clock pulse when the frame is dropped after too many collisions |

## Verification
A bad gap counter shows up as a start that comes a few clocks early or late, measured against the moment the carrier drops. A bad timer or exponent mask shows up at the next retry. The spacing from jam end to txGo either stops being a whole number of slots plus the fixed gap latency, or it implies a draw outside the allowed range. A stuck attempt counter shows up only at the end of a long sequence of collisions: the abort comes at the wrong attempt, or the capped and standard modes become indistinguishable. The bench therefore keeps one frame colliding until it aborts, in both strap settings.

// File: rtl/txdefer_pkg.sv
package txdefer_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEFER,
    ST_XMIT,
    ST_JAM,
    ST_BACKOFF,
    ST_ABORT
  } txState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic gapClr;
    logic loadJam;
    logic loadBackoff;
    logic colInc;
    logic attClr;
  } dpCmd_t;

  // conditions from datapath to control
  typedef struct packed {
    logic gapDone;
    logic jamLast;
    logic backoffDone;
    logic attemptsMaxed;
  } dpStat_t;

endpackage

// File: rtl/txdefer_dp.sv
module txdefer_dp
  import txdefer_pkg::*;
#(
  parameter int IFG_BITS    = 96,
  parameter int JAM_BITS    = 32,
  parameter int SLOT_BITS   = 512,
  parameter int ATTEMPT_MAX = 16,
  parameter int EXP_MAX     = 10,
  parameter int EXP_SHORT   = 4,
  parameter int LFSR_W      = 16,
  parameter int unsigned LFSR_SEED = 32'h0000ACE1
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    bitEn,
  input  logic    crs,
  input  logic    fullDuplex,
  input  logic    backoffCapStrap,
  input  dpCmd_t  cmd,
  output dpStat_t stat
);

  localparam int GAP_W   = $clog2(IFG_BITS + 1);
  localparam int ATT_W   = $clog2(ATTEMPT_MAX + 1);
  localparam int EXP_W   = $clog2(EXP_MAX + 1);
  localparam int BO_MAX  = ((1 << EXP_MAX) - 1) * SLOT_BITS;
  localparam int TMR_TOP = (BO_MAX > JAM_BITS) ? BO_MAX : JAM_BITS;
  localparam int TMR_W   = $clog2(TMR_TOP + 1);

  // ---------------- strap capture while reset is held ----------------
  logic shortMode;
  always_ff @(posedge clk) begin
    if (!rstN) shortMode <= backoffCapStrap;
  end

  // ---------------- interframe gap counter ----------------
  logic [GAP_W-1:0] gapCnt;
  logic crsEff;
  assign crsEff = crs && !fullDuplex;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                      gapCnt <= '0;
    else if (cmd.gapClr || crsEff)  gapCnt <= '0;
    else if (bitEn && gapCnt != GAP_W'(IFG_BITS))
      gapCnt <= gapCnt + GAP_W'(1);
  end

  // ---------------- free-running pseudo-random source ----------------
  logic [LFSR_W-1:0] lfsr;
  logic [LFSR_W-1:0] lfsrTaps;

  if (LFSR_W == 32) begin : g_taps32
    assign lfsrTaps = LFSR_W'(32'h8020_0003);
  end else begin : g_taps16
    assign lfsrTaps = LFSR_W'(16'hB400);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) lfsr <= LFSR_W'(LFSR_SEED);
    else       lfsr <= (lfsr >> 1) ^ (lfsr[0] ? lfsrTaps : '0);
  end

  // ---------------- attempt counter and exponent ----------------
  logic [ATT_W-1:0] attempts;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             attempts <= '0;
    else if (cmd.attClr)   attempts <= '0;
    else if (cmd.colInc)   attempts <= attempts + ATT_W'(1);
  end

  logic [EXP_W-1:0] expLimit;
  logic [EXP_W-1:0] expNow;
  assign expLimit = shortMode ? EXP_W'(EXP_SHORT) : EXP_W'(EXP_MAX);
  assign expNow   = (int'(attempts) < int'(expLimit)) ? EXP_W'(attempts) : expLimit;

  logic [EXP_MAX-1:0] expMask;
  for (genvar i = 0; i < EXP_MAX; i++) begin : g_mask
    assign expMask[i] = (i < int'(expNow));
  end

  logic [EXP_MAX-1:0] rndVal;
  assign rndVal = lfsr[EXP_MAX-1:0] & expMask;

  // ---------------- shared jam / backoff timer ----------------
  logic [TMR_W-1:0] tmr;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 tmr <= '0;
    else if (cmd.loadJam)      tmr <= TMR_W'(JAM_BITS);
    else if (cmd.loadBackoff)  tmr <= TMR_W'(int'(rndVal) * SLOT_BITS);
    else if (bitEn && tmr != '0) tmr <= tmr - TMR_W'(1);
  end

  assign stat.gapDone       = (gapCnt == GAP_W'(IFG_BITS));
  assign stat.jamLast       = bitEn && (tmr <= TMR_W'(1));
  assign stat.backoffDone   = (tmr == '0);
  assign stat.attemptsMaxed = (attempts == ATT_W'(ATTEMPT_MAX));

endmodule

// File: rtl/txdefer_ctrl.sv
module txdefer_ctrl
  import txdefer_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    txReq,
  input  logic    txEnd,
  input  logic    col,
  input  logic    fullDuplex,
  input  dpStat_t stat,
  output dpCmd_t  cmd,
  output logic    txGo,
  output logic    txJam,
  output logic    txAbort
);

  txState_t state, nextState;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    nextState = state;
    cmd       = '0;
    case (state)
      ST_IDLE: begin
        cmd.attClr = 1'b1;
        if (txReq) nextState = ST_DEFER;
      end
      ST_DEFER: begin
        if (!txReq)            nextState = ST_IDLE;
        else if (stat.gapDone) nextState = ST_XMIT;
      end
      ST_XMIT: begin
        cmd.gapClr = 1'b1;
        if (col && !fullDuplex) begin
          cmd.colInc  = 1'b1;
          cmd.loadJam = 1'b1;
          nextState   = ST_JAM;
        end else if (txEnd) begin
          nextState = ST_IDLE;
        end
      end
      ST_JAM: begin
        cmd.gapClr = 1'b1;
        if (stat.jamLast) begin
          if (stat.attemptsMaxed) begin
            nextState = ST_ABORT;
          end else begin
            cmd.loadBackoff = 1'b1;
            nextState       = ST_BACKOFF;
          end
        end
      end
      ST_BACKOFF: begin
        if (stat.backoffDone) begin
          cmd.gapClr = 1'b1;
          nextState  = ST_DEFER;
        end
      end
      ST_ABORT: nextState = ST_IDLE;
      default:  nextState = ST_IDLE;
    endcase
  end

  assign txGo    = (state == ST_XMIT);
  assign txJam   = (state == ST_JAM);
  assign txAbort = (state == ST_ABORT);

endmodule

// File: rtl/txdefer_top.sv
module txdefer_top
  import txdefer_pkg::*;
#(
  parameter int IFG_BITS    = 96,
  parameter int JAM_BITS    = 32,
  parameter int SLOT_BITS   = 512,
  parameter int ATTEMPT_MAX = 16,
  parameter int EXP_MAX     = 10,
  parameter int EXP_SHORT   = 4,
  parameter int LFSR_W      = 16
) (
  input  logic clk,
  input  logic rstN,
  input  logic bitEn,
  input  logic crs,
  input  logic col,
  input  logic fullDuplex,
  input  logic backoffCapStrap,
  input  logic txReq,
  input  logic txEnd,
  output logic txGo,
  output logic txJam,
  output logic txAbort
);

  dpCmd_t  cmd;
  dpStat_t stat;

  txdefer_dp #(
    .IFG_BITS(IFG_BITS), .JAM_BITS(JAM_BITS), .SLOT_BITS(SLOT_BITS),
    .ATTEMPT_MAX(ATTEMPT_MAX), .EXP_MAX(EXP_MAX), .EXP_SHORT(EXP_SHORT),
    .LFSR_W(LFSR_W)
  ) dp_i (
    .clk(clk), .rstN(rstN), .bitEn(bitEn), .crs(crs),
    .fullDuplex(fullDuplex), .backoffCapStrap(backoffCapStrap),
    .cmd(cmd), .stat(stat)
  );

  txdefer_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .txReq(txReq), .txEnd(txEnd), .col(col),
    .fullDuplex(fullDuplex), .stat(stat), .cmd(cmd),
    .txGo(txGo), .txJam(txJam), .txAbort(txAbort)
  );

endmodule

// File: rtl/txdefer_chk.sv
module txdefer_chk #(
  parameter int JAM_BITS = 32
) (
  input logic clk,
  input logic rstN,
  input logic bitEn,
  input logic col,
  input logic fullDuplex,
  input logic txReq,
  input logic txGo,
  input logic txJam,
  input logic txAbort
);

  // bit ticks already spent in the current jam, before this cycle
  logic [31:0] jamTicks;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)      jamTicks <= '0;
    else if (txJam) jamTicks <= jamTicks + 32'(bitEn);
    else            jamTicks <= '0;
  end

  assert_go_needs_req_R2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(txGo) |-> $past(txReq));

  assert_jam_cause_R4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(txJam) |-> $past(txGo && col && !fullDuplex));

  assert_jam_bound_R5: assert property (@(posedge clk) disable iff (!rstN)
    txJam |-> (jamTicks < 32'(JAM_BITS)));

  assert_jam_full_R5: assert property (@(posedge clk) disable iff (!rstN)
    $fell(txJam) |-> ($past(jamTicks) == 32'(JAM_BITS - 1)) && $past(bitEn));

  assert_fdx_no_jam_R8: assert property (@(posedge clk) disable iff (!rstN)
    (txGo && col && fullDuplex) |=> !txJam);

  assert_abort_pulse_R9: assert property (@(posedge clk) disable iff (!rstN)
    txAbort |=> !txAbort);

  assert_abort_after_jam_R9: assert property (@(posedge clk) disable iff (!rstN)
    txAbort |-> $past(txJam));

endmodule

bind txdefer_top txdefer_chk #(.JAM_BITS(JAM_BITS)) chk_i (
  .clk(clk), .rstN(rstN), .bitEn(bitEn), .col(col), .fullDuplex(fullDuplex),
  .txReq(txReq), .txGo(txGo), .txJam(txJam), .txAbort(txAbort)
);

// File: tb/txdefer_top_tb_top.sv
`timescale 1ns/1ps
module txdefer_top_tb_top;

  localparam int IFG    = 6;
  localparam int JAM    = 4;
  localparam int SLOT   = 8;
  localparam int ATT    = 16;
  localparam int EMAX   = 10;
  localparam int ESHORT = 4;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rstN = 1'b0;
  logic bitEn = 1'b1, crs = 1'b0, col = 1'b0, fullDuplex = 1'b0;
  logic strap = 1'b0, txReq = 1'b0, txEnd = 1'b0;
  logic txGo, txJam, txAbort;

  txdefer_top #(
    .IFG_BITS(IFG), .JAM_BITS(JAM), .SLOT_BITS(SLOT),
    .ATTEMPT_MAX(ATT), .EXP_MAX(EMAX), .EXP_SHORT(ESHORT), .LFSR_W(16)
  ) dut_i (
    .clk(clk), .rstN(rstN), .bitEn(bitEn), .crs(crs), .col(col),
    .fullDuplex(fullDuplex), .backoffCapStrap(strap), .txReq(txReq),
    .txEnd(txEnd), .txGo(txGo), .txJam(txJam), .txAbort(txAbort)
  );

  typedef enum int {EV_GO = 0, EV_JAM = 1, EV_ABORT = 2} evKind_t;
  typedef struct {
    evKind_t kind;
    string   tag;
  } evItem_t;

  evItem_t expQ[$];
  int nChecks = 0;
  int nFail   = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic void expectEv(evKind_t k, string tag);
    evItem_t it;
    it.kind = k;
    it.tag  = tag;
    expQ.push_back(it);
  endfunction

  task automatic popCompare(input evKind_t k);
    evItem_t it;
    if (expQ.size() == 0) begin
      check(1'b0, "R4 R8 scoreboard unexpected event", int'(k), -1);
    end else begin
      it = expQ.pop_front();
      check(it.kind == k, it.tag, int'(k), int'(it.kind));
    end
  endtask

  // monitor: pops expectations as output events appear
  logic pGo = 1'b0, pJam = 1'b0, pAb = 1'b0;
  always @(negedge clk) begin
    if (rstN) begin
      if (txGo && !pGo)    popCompare(EV_GO);
      if (txJam && !pJam)  popCompare(EV_JAM);
      if (txAbort && !pAb) popCompare(EV_ABORT);
    end
    pGo  = txGo;
    pJam = txJam;
    pAb  = txAbort;
  end

  task automatic summary();
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nFail++;
      $display("FAIL R2 run timeout actual=hung expected=completion");
      summary();
      $finish;
    end
  end

  task automatic doReset(input logic s);
    rstN = 1'b0; strap = s; txReq = 1'b0; txEnd = 1'b0;
    col = 1'b0; crs = 1'b0; fullDuplex = 1'b0; bitEn = 1'b1;
    repeat (5) @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic waitGo(output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!txGo);
  endtask

  task automatic startFrame();
    int n;
    expectEv(EV_GO, "R2 start");
    txReq = 1'b1;
    waitGo(n);
  endtask

  task automatic endFrame();
    txReq = 1'b0; txEnd = 1'b1;
    @(negedge clk);
    txEnd = 1'b0;
    check(!txGo, "R2 txGo drops after txEnd", txGo, 0);
  endtask

  // one collision on the current attempt; txGo is high on entry
  task automatic collideOnce(input int n, input bit capped, input bit slow,
                             output int r, output bit ab);
    int k, ticks, cnt, rem;
    k = (n < (capped ? ESHORT : EMAX)) ? n : (capped ? ESHORT : EMAX);
    r = -1;
    expectEv(EV_JAM, "R4 jam event");
    if (n == ATT) expectEv(EV_ABORT, "R9 abort event");
    else          expectEv(EV_GO, "R6 retry event");
    col = 1'b1;
    @(negedge clk);
    col = 1'b0;
    check(txJam && !txGo, "R4 jam one clock after collision", {txGo, txJam}, 1);
    ticks = 0;
    while (txJam) begin
      ticks += int'(bitEn);
      @(negedge clk);
      if (slow) bitEn = ~bitEn;
    end
    bitEn = 1'b1;
    check(ticks == JAM, "R5 jam length in bit ticks", ticks, JAM);
    ab = txAbort;
    if (n == ATT) begin
      check(txAbort, "R9 abort at attempt limit", txAbort, 1);
      txReq = 1'b0;
      @(negedge clk);
      check(!txAbort, "R9 abort lasts one clock", txAbort, 0);
      return;
    end
    check(!txAbort, "R9 no abort before limit", txAbort, 0);
    cnt = 0;
    while (!txGo) begin
      @(negedge clk);
      cnt++;
    end
    if (!slow) begin
      rem = cnt - IFG - 2;
      check(rem >= 0 && (rem % SLOT) == 0, "R6 retry spacing is whole slots plus gap",
            cnt, IFG + 2);
      r = rem / SLOT;
      if (capped)
        check(r >= 0 && r < (1 << k), "R10 draw within capped range", r, (1 << k) - 1);
      else
        check(r >= 0 && r < (1 << k), "R6 draw within range", r, (1 << k) - 1);
    end
  endtask

  initial begin
    int n, r, maxR;
    bit ab, seen;

    // ---------------- R1 reset ----------------
    doReset(1'b0);
    check({txGo, txJam, txAbort} == 3'b000, "R1 outputs low after reset",
          {txGo, txJam, txAbort}, 0);
    @(negedge clk);
    check({txGo, txJam, txAbort} == 3'b000, "R1 outputs stay low",
          {txGo, txJam, txAbort}, 0);
    repeat (20) @(negedge clk);

    // ---------------- R2 start on an idle line ----------------
    expectEv(EV_GO, "R2 go event");
    txReq = 1'b1;
    waitGo(n);
    check(n == 2, "R2 go latency on idle line", n, 2);
    endFrame();

    // ---------------- R3 carrier deferral and restart ----------------
    repeat (20) @(negedge clk);
    crs = 1'b1;
    @(negedge clk);
    txReq = 1'b1;
    seen = 0;
    repeat (20) begin
      @(negedge clk);
      if (txGo) seen = 1;
    end
    check(!seen, "R3 held while carrier busy", seen, 0);
    crs = 1'b0;
    repeat (3) @(negedge clk);
    crs = 1'b1;
    @(negedge clk);
    expectEv(EV_GO, "R3 go after gap");
    crs = 1'b0;
    waitGo(n);
    check(n == IFG + 1, "R3 gap restarts after carrier glitch", n, IFG + 1);
    endFrame();

    // ---------------- R8 full duplex ----------------
    repeat (20) @(negedge clk);
    fullDuplex = 1'b1;
    crs = 1'b1;
    repeat (3) @(negedge clk);
    expectEv(EV_GO, "R8 go event");
    txReq = 1'b1;
    waitGo(n);
    check(n == 2, "R8 carrier ignored for deferral", n, 2);
    col = 1'b1;
    @(negedge clk);
    col = 1'b0;
    check(txGo && !txJam, "R8 collision ignored", {txGo, txJam}, 2);
    @(negedge clk);
    check(txGo && !txJam, "R8 still sending", {txGo, txJam}, 2);
    endFrame();
    fullDuplex = 1'b0;
    crs = 1'b0;

    // ---------------- R4 R5 jam with sparse bit enable ----------------
    repeat (20) @(negedge clk);
    startFrame();
    collideOnce(1, 1'b0, 1'b1, r, ab);
    endFrame();

    // ---------------- R7 carrier after backoff ----------------
    repeat (20) @(negedge clk);
    startFrame();
    expectEv(EV_JAM, "R4 jam event");
    expectEv(EV_GO, "R7 retry event");
    col = 1'b1;
    @(negedge clk);
    col = 1'b0;
    while (txJam) @(negedge clk);
    crs = 1'b1;
    seen = 0;
    repeat (40) begin
      @(negedge clk);
      if (txGo) seen = 1;
    end
    check(!seen, "R7 no retry while carrier busy", seen, 0);
    crs = 1'b0;
    waitGo(n);
    check(n == IFG + 1, "R7 full gap after backoff", n, IFG + 1);
    endFrame();

    // ---------------- R6 R9 standard mode until abort ----------------
    repeat (20) @(negedge clk);
    startFrame();
    maxR = 0;
    for (int i = 1; i <= ATT; i++) begin
      collideOnce(i, 1'b0, 1'b0, r, ab);
      if (r > maxR) maxR = r;
    end
    check(maxR >= (1 << ESHORT), "R10 standard draws exceed capped range", maxR, 1 << ESHORT);
    seen = 0;
    repeat (30) begin
      @(negedge clk);
      if (txGo) seen = 1;
    end
    check(!seen, "R9 no retry after abort", seen, 0);

    // ---------------- R10 capped mode, strap changed after reset ----------------
    doReset(1'b1);
    @(negedge clk);
    strap = 1'b0;
    repeat (20) @(negedge clk);
    startFrame();
    maxR = 0;
    for (int i = 1; i <= ATT; i++) begin
      collideOnce(i, 1'b1, 1'b0, r, ab);
      if (r > maxR) maxR = r;
    end
    check(maxR < (1 << ESHORT), "R10 strap change after reset ignored", maxR, (1 << ESHORT) - 1);

    // ---------------- R11 count restarts for a new frame ----------------
    repeat (20) @(negedge clk);
    startFrame();
    collideOnce(1, 1'b1, 1'b0, r, ab);
    check(r >= 0 && r < 2, "R11 first collision of new frame draws 0 or 1", r, 1);
    endFrame();

    repeat (10) @(negedge clk);
    check(expQ.size() == 0, "R9 scoreboard drained", expQ.size(), 0);
    finished = 1;
    summary();
    $finish;
  end

endmodule